// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 64-bit integer datapath and a byte-addressed data memory that is 64 bits wide. For a store it takes a byte address, a size code and the register value. It then produces doubleword-aligned memory writes, with the data steered onto the right byte lanes and a byte-enable mask. For a load it reads the memory doubleword or doublewords that hold the value. It extracts the addressed bytes and returns a 64-bit result, sign-extended or zero-extended according to the size and an unsigned flag.

Accesses do not have to be naturally aligned. An access whose bytes run past the end of a doubleword is done in hardware as two memory beats: the aligned doubleword first, then the next one. The bytes of both beats are merged. A request is accepted only while the unit is idle. The unit holds its own copy of the request until the last beat finishes. It then pulses `done` for one cycle, and in that cycle a load result is presented on `ld_data`. The memory returns read data one cycle after the beat that requested it.

Top module: `lsa_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `mem_en` are low until a request is accepted.
- R2: Byte order is little endian: byte k of a loaded or stored value lives at byte address `req_addr + k`.
- R3: A store writes exactly N bytes, where the size code gives N (2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 8). The bytes are taken from the lowest N bytes of `req_wdata`, and every other memory byte is left unchanged. `mem_be` is never all-zero during a beat.
- R4: A load with size code 2'b00, 2'b01 or 2'b10 and `req_unsigned` = 0 copies bit 8N-1 of the loaded value into all higher bits of `ld_data`.
- R5: A load with `req_unsigned` = 1 and size code 2'b00, 2'b01 or 2'b10 clears all bits of `ld_data` above bit 8N-1.
- R6: A load with size code 2'b11 returns all 64 bits as stored, at any byte offset.
- R7: When `req_addr[2:0] + N > 8`, the access takes two beats. The first is at `req_addr` with its low three bits cleared, and the second is at that address plus 8. Otherwise the access takes exactly one beat, at the aligned address.
- R8: `done` is high for exactly one cycle. It occurs two cycles after the accepting clock edge for a one-beat access and three cycles after it for a two-beat access. `busy` is high from the accepting edge through the `done` cycle.
- R9: `req_valid` and the request fields are ignored while `busy` is high: they start no access and do not alter the access in progress.
- R10: `mem_addr[2:0]` is zero on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 00 byte, 01 halfword, 10 word, 11 doubleword |
| req_unsigned | input | 1 | Load zero-extends when set |
| req_addr | input | AW (16) | Byte address |
| req_wdata | input | DW (64) | Store source value |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final beat complete; load result valid this cycle |
| ld_data | output | DW (64) | Extended load result, zero outside a load's done cycle |
| mem_en | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW (16) | Doubleword-aligned beat address |
| mem_be | output | DW/8 (8) | Byte enables of the beat |
| mem_wdata | output | DW (64) | Lane-steered write data |
| mem_rdata | input | DW (64) | Read data, valid the cycle after a read beat |

## Verification
The bench sweeps every size code against every byte offset within a doubleword, for stores and for signed and unsigned loads. Each access is checked against a byte-array model of memory. A steering bug with the wrong shift direction or a reversed byte order would put bytes at mirrored addresses. A bad split rule would show up at the offsets where the access just fits or just overflows: for example, a word at offset 4 must take one beat and a word at offset 5 must take two. Such a bug would either drop the overflow bytes or issue a spurious second beat, and the beat count and memory contents would expose it. Memory bytes are chosen so that both sign-bit values occur, which catches an extension bug taken from the wrong byte or ignoring the unsigned flag. Requests are also held asserted with different fields while the unit is busy, so a design that latched them mid-access would write the wrong bytes or run extra beats.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_DBL  = 2'b11
   } lsa_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT0 = 2'd1,
      ST_BEAT1 = 2'd2,
      ST_FIN   = 2'd3
   } lsa_state_e;

   // number of bytes moved by a size code
   function automatic int size_bytes(input logic [1:0] sz);
      return 1 << int'(sz);
   endfunction

endpackage

// File: rtl/lsa_store_steer.sv
// Places the low N bytes of the store value onto a two-doubleword lane
// window starting at the byte offset; upper half belongs to the second beat.
module lsa_store_steer #(
   parameter  int DW   = 64,
   localparam int NB   = DW / 8,
   localparam int OFFW = $clog2(NB)
) (
   input  logic [OFFW-1:0] off,
   input  logic [1:0]      size,
   input  logic [DW-1:0]   wdata,
   output logic [NB-1:0]   be_lo,
   output logic [NB-1:0]   be_hi,
   output logic [DW-1:0]   wd_lo,
   output logic [DW-1:0]   wd_hi
);
   import lsa_pkg::*;

   logic [2*NB-1:0] win_be;
   logic [2*DW-1:0] win_wd;
   int              nbytes;

   assign nbytes = size_bytes(size);

   for (genvar i = 0; i < 2*NB; i++) begin : g_lane
      logic [OFFW-1:0] src;
      logic            hit;
      assign src = OFFW'(i) - off;
      assign hit = (i >= int'(off)) && ((i - int'(off)) < nbytes);
      assign win_be[i]         = hit;
      assign win_wd[8*i +: 8]  = hit ? wdata[8*src +: 8] : 8'h00;
   end

   assign be_lo = win_be[NB-1:0];
   assign be_hi = win_be[2*NB-1:NB];
   assign wd_lo = win_wd[DW-1:0];
   assign wd_hi = win_wd[2*DW-1:DW];

endmodule

// File: rtl/lsa_load_merge.sv
// Extracts N bytes from a two-doubleword window at the byte offset and
// extends them to the full width.
module lsa_load_merge #(
   parameter  int DW   = 64,
   localparam int NB   = DW / 8,
   localparam int OFFW = $clog2(NB)
) (
   input  logic [OFFW-1:0] off,
   input  logic [1:0]      size,
   input  logic            uns,
   input  logic [DW-1:0]   win_lo,
   input  logic [DW-1:0]   win_hi,
   output logic [DW-1:0]   value
);
   import lsa_pkg::*;

   logic [2*DW-1:0] window;
   logic [DW-1:0]   raw;
   logic            sgn;
   logic [7:0]      fill;
   int              nbytes;

   assign window = {win_hi, win_lo};
   assign nbytes = size_bytes(size);

   for (genvar j = 0; j < NB; j++) begin : g_pick
      logic [OFFW:0] idx;
      assign idx = (OFFW+1)'(j) + {1'b0, off};
      assign raw[8*j +: 8] = window[8*idx +: 8];
   end

   always_comb begin
      case (lsa_size_e'(size))
         SZ_BYTE: sgn = raw[7];
         SZ_HALF: sgn = raw[15];
         SZ_WORD: sgn = raw[31];
         default: sgn = raw[DW-1];
      endcase
   end

   assign fill = uns ? 8'h00 : {8{sgn}};

   for (genvar j = 0; j < NB; j++) begin : g_ext
      assign value[8*j +: 8] = (j < nbytes) ? raw[8*j +: 8] : fill;
   end

endmodule

// File: rtl/lsa_seq.sv
// Request capture and beat sequencing.
module lsa_seq #(
   parameter int AW = 16,
   parameter int DW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic              req_unsigned,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic              split,
   input  logic [DW-1:0]     mem_rdata,
   output lsa_pkg::lsa_state_e st,
   output logic              h_store,
   output logic [1:0]        h_size,
   output logic              h_uns,
   output logic [AW-1:0]     h_addr,
   output logic [DW-1:0]     h_wdata,
   output logic [DW-1:0]     beat0_q
);
   import lsa_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         h_store <= 1'b0;
         h_size  <= 2'b00;
         h_uns   <= 1'b0;
         h_addr  <= '0;
         h_wdata <= '0;
         beat0_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  h_store <= req_store;
                  h_size  <= req_size;
                  h_uns   <= req_unsigned;
                  h_addr  <= req_addr;
                  h_wdata <= req_wdata;
                  st      <= ST_BEAT0;
               end
            end
            ST_BEAT0: st <= split ? ST_BEAT1 : ST_FIN;
            ST_BEAT1: begin
               beat0_q <= mem_rdata;
               st      <= ST_FIN;
            end
            default:  st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit #(
   parameter int AW        = 16,
   parameter int DW        = 64,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic              req_unsigned,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DW-1:0]     ld_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW/8-1:0]   mem_be,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata
);
   import lsa_pkg::*;

   localparam int NB   = DW / 8;
   localparam int OFFW = $clog2(NB);

   if (DW != 64) begin : g_bad_dw
      $error("lsa_unit: DW must be 64 for doubleword accesses");
   end
   if (AW <= OFFW) begin : g_bad_aw
      $error("lsa_unit: AW must exceed the byte-offset width");
   end

   lsa_state_e        st;
   logic              h_store, h_uns, split;
   logic [1:0]        h_size;
   logic [AW-1:0]     h_addr, base;
   logic [DW-1:0]     h_wdata, beat0_q, ld_value, win_lo, win_hi;
   logic [NB-1:0]     be_lo, be_hi;
   logic [DW-1:0]     wd_lo, wd_hi;
   logic              second;

   lsa_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
      .req_unsigned(req_unsigned), .req_addr(req_addr), .req_wdata(req_wdata),
      .split(split), .mem_rdata(mem_rdata),
      .st(st), .h_store(h_store), .h_size(h_size), .h_uns(h_uns),
      .h_addr(h_addr), .h_wdata(h_wdata), .beat0_q(beat0_q)
   );

   lsa_store_steer #(.DW(DW)) u_steer (
      .off(h_addr[OFFW-1:0]), .size(h_size), .wdata(h_wdata),
      .be_lo(be_lo), .be_hi(be_hi), .wd_lo(wd_lo), .wd_hi(wd_hi)
   );

   assign split  = |be_hi;
   assign win_lo = split ? beat0_q : mem_rdata;
   assign win_hi = split ? mem_rdata : '0;

   lsa_load_merge #(.DW(DW)) u_merge (
      .off(h_addr[OFFW-1:0]), .size(h_size), .uns(h_uns),
      .win_lo(win_lo), .win_hi(win_hi), .value(ld_value)
   );

   assign base   = {h_addr[AW-1:OFFW], {OFFW{1'b0}}};
   assign second = (st == ST_BEAT1);
   assign busy   = (st != ST_IDLE);
   assign done   = (st == ST_FIN);
   assign mem_en = (st == ST_BEAT0) || second;
   assign mem_we = mem_en && h_store;
   assign mem_addr = second ? base + AW'(NB) : base;
   assign mem_be   = mem_en ? (second ? be_hi : be_lo) : '0;

   if (GATE_IDLE) begin : g_gated
      assign mem_wdata = mem_we ? (second ? wd_hi : wd_lo) : '0;
      assign ld_data   = (done && !h_store) ? ld_value : '0;
   end else begin : g_open
      assign mem_wdata = second ? wd_hi : wd_lo;
      assign ld_data   = ld_value;
   end

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
   parameter int AW = 16,
   parameter int DW = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            mem_en,
   input logic [AW-1:0]   mem_addr,
   input logic [DW/8-1:0] mem_be
);
   localparam int NB = DW / 8;

   always @(negedge clk) begin
      if (!rst_n) begin
         a_reset_idle_r1: assert (!busy && !done && !mem_en);
      end
   end

   p_be_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_be != '0));

   p_second_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + AW'(NB)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_no_beat_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_en);

   p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_addr[2:0] == 3'b000));

endmodule

bind lsa_unit lsa_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .mem_en(mem_en), .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/tb_lsa_unit.sv
`timescale 1ns/1ps
module tb_lsa_unit;
   localparam int AW = 16;
   localparam int DW = 64;
   localparam int MB = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
   logic [1:0]    req_size = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy, done, mem_en, mem_we;
   logic [DW-1:0] ld_data, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_be;

   logic [7:0] mem_b [MB];
   logic [7:0] shadow [MB];
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lsa_unit #(.AW(AW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .ld_data(ld_data),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // byte-array memory, read data one cycle after the beat
   always @(posedge clk) begin
      if (mem_en) begin
         int b;
         b = int'(mem_addr[5:3]) * 8;
         if (mem_we) begin
            for (int l = 0; l < 8; l++)
               if (mem_be[l]) mem_b[b+l] <= mem_wdata[8*l +: 8];
         end else begin
            for (int l = 0; l < 8; l++)
               mem_rdata[8*l +: 8] <= mem_b[b+l];
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                         input int a, input logic [63:0] wd, input bit junk,
                         input string tag);
      int n, off, cyc, beats, bad, aligned;
      bit got, split;
      logic [63:0] res, exp;
      logic [AW-1:0] ba [2];
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
      req_addr = AW'(a); req_wdata = wd;
      cyc = 0; beats = 0; got = 1'b0; res = '0;
      ba[0] = '1; ba[1] = '1;
      while (!got && cyc < 10) begin
         @(negedge clk);
         cyc++;
         if (junk) begin
            req_valid = 1'b1; req_store = ~st; req_size = ~sz;
            req_addr = AW'(a ^ 5); req_wdata = ~wd;
         end else begin
            req_valid = 1'b0;
         end
         if (mem_en) begin
            if (beats < 2) ba[beats] = mem_addr;
            beats++;
         end
         if (done) begin
            got = 1'b1;
            res = ld_data;
            req_valid = 1'b0;
         end
      end
      n = 1 << int'(sz);
      off = a % 8;
      split = (off + n) > 8;
      aligned = a - off;
      // R8 timing and R7 beat count
      chk(cyc == (split ? 3 : 2) && beats == (split ? 2 : 1),
          {tag, " R7/R8 cycles,beats"}, 64'(cyc*16+beats),
          64'((split ? 3 : 2)*16 + (split ? 2 : 1)));
      // R7/R10 beat addresses
      chk(ba[0] == AW'(aligned) && (!split || ba[1] == AW'(aligned + 8)),
          {tag, " R7/R10 beat addr"}, {32'(ba[0]), 32'(ba[1])},
          {32'(aligned), split ? 32'(aligned + 8) : 32'(ba[1])});
      if (st) begin
         for (int k = 0; k < n; k++) shadow[a+k] = wd[8*k +: 8];
         bad = 0;
         for (int i = 0; i < MB; i++) if (mem_b[i] !== shadow[i]) bad++;
         chk(bad == 0, {tag, " R2/R3 memory bytes"}, 64'(bad), 64'd0);
      end else begin
         exp = '0;
         for (int k = 0; k < n; k++) exp[8*k +: 8] = shadow[a+k];
         if (n < 8 && !uns && shadow[a+n-1][7])
            for (int k = n; k < 8; k++) exp[8*k +: 8] = 8'hFF;
         chk(res === exp, {tag, " R2 load value"}, res, exp);
      end
   endtask

   initial begin
      #(8*200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MB; i++) begin
         mem_b[i]  = 8'((i*73 + 29) & 255);
         shadow[i] = 8'((i*73 + 29) & 255);
      end
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_en, "R1 reset idle",
          {61'd0, busy, done, mem_en}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_en, "R1 after release",
          {61'd0, busy, done, mem_en}, 64'd0);

      for (int sz = 0; sz < 4; sz++) begin
         for (int off = 0; off < 8; off++) begin
            logic [63:0] wd;
            wd = 64'h8F7E6D5C4B3A2918 + 64'(sz*16 + off) * 64'h0101010101010101;
            if (off % 2 == 1) wd = wd ^ 64'h8080808080808080;
            access(1'b1, 2'(sz), 1'b0, 16 + off, wd, 1'b0, "R3 store");
            access(1'b0, 2'(sz), 1'b0, 16 + off, '0, 1'b0,
                   sz == 3 ? "R6 dbl load" : "R4 signed load");
            access(1'b0, 2'(sz), 1'b1, 16 + off, '0, 1'b0,
                   sz == 3 ? "R6 dbl load uns" : "R5 unsigned load");
            access(1'b0, 2'(sz), 1'b0, 32 + off, '0, 1'b0,
                   sz == 3 ? "R6 dbl load" : "R4 signed load b");
         end
      end

      // R9: request fields toggle while busy
      access(1'b1, 2'b10, 1'b0, 45, 64'h1122334455667788, 1'b1, "R9 store busy");
      access(1'b0, 2'b10, 1'b0, 45, '0, 1'b1, "R9 load busy");
      access(1'b1, 2'b00, 1'b0, 40, 64'h00000000000000A5, 1'b1, "R9 byte busy");
      access(1'b0, 2'b00, 1'b1, 40, '0, 1'b1, "R9 byte load busy");
      @(negedge clk);
      chk(!busy && !mem_en, "R9 idle after access",
          {62'd0, busy, mem_en}, 64'd0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule